// File: doc/BRIEF.md
# Parallel Converter Port Host Sequencer

This block sits in the system clock domain and masters the 8-bit three-state port of an external 12-bit successive-approximation converter. A client hands it one control byte through a valid/ready request. The block writes that byte with a timed chip-select/write-strobe pulse, then releases the bus and waits for the converter's active-low end-of-conversion flag. Once the flag is seen, it runs two timed read cycles, low byte first and high byte second, steering them with a byte-select line. It then joins the two halves into a 16-bit result and offers it on a valid/ready output.

Every bus timing minimum is a parameter in nanoseconds and is turned into a whole number of system clocks by rounding up against a clock-period parameter. The polarity bit of the control byte that was written decides how the 12-bit result is widened: zero-extended for plain binary and sign-extended for two's complement. Only one transaction is in flight. A watchdog on the flag wait ends a conversion that never completes with an error-marked result.

The sequencer is a Moore machine with these states. `ST_IDLE` moves to `ST_WR_STROBE` when a request is accepted. `ST_WR_STROBE` moves to `ST_WR_HOLD` after the write count. `ST_WR_HOLD` moves to `ST_EOC_WAIT` after one cycle. `ST_EOC_WAIT` moves to `ST_RD_LOW` when the synchronised flag is low, or to `ST_RESULT` when the watchdog expires. `ST_RD_LOW` moves to `ST_RD_GAP` after the access count. `ST_RD_GAP` moves to `ST_RD_HIGH` after the release count. `ST_RD_HIGH` moves to `ST_RD_RELEASE` after the access count. `ST_RD_RELEASE` moves to `ST_RESULT` after the release count. `ST_RESULT` returns to `ST_IDLE` when the result is taken.

Top module: `adc_bus_master`

## Requirements
- R1: After reset, chip-select, write and read strobes are high, byte-select is low, the bus driver is off, `req_ready` is 1 and `res_valid` is 0.
- R2: In the cycle after a request is accepted, chip-select and write strobe go low and the accepted control byte is driven with `adc_dq_oe` = 1. After the write count, both strobes rise for one cycle while the byte is still driven, and then the driver turns off.
- R3: The write count is the larger of ceil(`WR_PULSE_NS`/`CLK_NS`) and ceil(`WR_SETUP_NS`/`CLK_NS`). This is 4 cycles with the defaults.
- R4: The end-of-conversion flag passes through a two-stage synchroniser. Reading starts in the cycle after the synchronised flag is sampled low, and no read strobe occurs before that.
- R5: The low read holds chip-select and read strobe low with byte-select low for ceil(`RD_ACCESS_NS`/`CLK_NS`) cycles. The bus value is captured at the last edge of that interval.
- R6: Between the two reads, chip-select and read strobe stay high for ceil(`RD_RELEASE_NS`/`CLK_NS`) cycles with byte-select already high. The high read then lasts as long as the low read and keeps byte-select high.
- R7: After the high read, the strobes stay high for the release count before the result is offered. The bus driver is never on while the read strobe is low.
- R8: The result is {high[3:0], low[7:0]}. Bits 15..12 copy bit 11 when bit 3 of the written control byte is 1 (bipolar) and are zero when it is 0. Bus bits 7..4 of the high read never affect the result.
- R9: `res_valid` stays 1, and `res_data` and `res_err` stay unchanged, until `res_ready` is sampled 1. `res_err` is 0 for a completed read.
- R10: `req_ready` is 1 only in idle, so a request held valid during a transaction is neither accepted nor allowed to disturb the bus.
- R11: If the synchronised flag stays high for `EOC_TIMEOUT` cycles of waiting, the result is offered with `res_err` = 1 and `res_data` = 0, and no read cycle takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_ctrl | input | 8 | Control byte to write to the converter |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Client takes the result |
| res_data | output | 16 | Widened conversion result |
| res_err | output | 1 | Flag wait timed out |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hben | output | 1 | Byte-select: 0 low byte, 1 high nibble |
| adc_dq_o | output | 8 | Data driven onto the bus |
| adc_dq_oe | output | 1 | Bus driver enable |
| adc_dq_i | input | 8 | Data read from the bus |
| adc_eoc_n | input | 1 | End-of-conversion flag, active low |

## Verification
The assertions assume that reset is applied before any request. They also assume that the converter flag only drops after a write has been made, and that it stays low until the host's first read strobe, so the sequencer never sees a stale completion. The bench acts as the converter. It lowers the flag only while the sequencer waits, raises it as soon as it sees chip-select and read strobe low together, and keeps byte data stable through each read. `res_ready` is held low for chosen spans to exercise the hold rule.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_STROBE,
        ST_WR_HOLD,
        ST_EOC_WAIT,
        ST_RD_LOW,
        ST_RD_GAP,
        ST_RD_HIGH,
        ST_RD_RELEASE,
        ST_RESULT
    } bus_state_e;

    // whole clocks covering a nanosecond minimum, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_flag_sync.sv
module adc_flag_sync #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RESET_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RESET_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_result_join.sv
module adc_result_join #(
    parameter int LO_W  = 8,
    parameter int RAW_W = 12,
    parameter int OUT_W = 16
) (
    input  logic [LO_W-1:0]       lo_byte,
    input  logic [RAW_W-LO_W-1:0] hi_part,
    input  logic                  bipolar,
    output logic [OUT_W-1:0]      value
);
    logic [RAW_W-1:0] raw;
    assign raw = {hi_part, lo_byte};

    generate
        if (OUT_W > RAW_W) begin : g_widen
            assign value = {{(OUT_W-RAW_W){bipolar & raw[RAW_W-1]}}, raw};
        end else begin : g_trunc
            assign value = raw[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/adc_bus_master.sv
module adc_bus_master
    import adc_bus_pkg::*;
#(
    parameter int CLK_NS        = 20,
    parameter int WR_PULSE_NS   = 80,
    parameter int WR_SETUP_NS   = 60,
    parameter int RD_ACCESS_NS  = 120,
    parameter int RD_RELEASE_NS = 70,
    parameter int EOC_TIMEOUT   = 4096,
    parameter int SYNC_STAGES   = 2,
    parameter int BIP_BIT       = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_ctrl,
    output logic        res_valid,
    input  logic        res_ready,
    output logic [15:0] res_data,
    output logic        res_err,
    output logic        adc_cs_n,
    output logic        adc_wr_n,
    output logic        adc_rd_n,
    output logic        adc_hben,
    output logic [7:0]  adc_dq_o,
    output logic        adc_dq_oe,
    input  logic [7:0]  adc_dq_i,
    input  logic        adc_eoc_n
);
    localparam int NW_CYC  = max2(ns_to_cyc(WR_PULSE_NS, CLK_NS), ns_to_cyc(WR_SETUP_NS, CLK_NS));
    localparam int NA_CYC  = ns_to_cyc(RD_ACCESS_NS, CLK_NS);
    localparam int NR_CYC  = ns_to_cyc(RD_RELEASE_NS, CLK_NS);
    localparam int MAX_CYC = max2(max2(NW_CYC, NA_CYC), max2(NR_CYC, EOC_TIMEOUT));
    localparam int CW      = $clog2(MAX_CYC + 1);

    bus_state_e       state, state_nx;
    logic [CW-1:0]    cnt;
    logic             eoc_seen_n;
    logic [7:0]       ctrl_q;
    logic [7:0]       lo_q;
    logic [3:0]       hi_q;
    logic             err_q;

    logic wr_done, rd_done, gap_done, wait_expired;
    assign wr_done      = (cnt == CW'(NW_CYC - 1));
    assign rd_done      = (cnt == CW'(NA_CYC - 1));
    assign gap_done     = (cnt == CW'(NR_CYC - 1));
    assign wait_expired = (cnt == CW'(EOC_TIMEOUT - 1));

    adc_flag_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_eoc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_eoc_n),
        .q     (eoc_seen_n)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_WR_STROBE;
            ST_WR_STROBE:  if (wr_done)   state_nx = ST_WR_HOLD;
            ST_WR_HOLD:                   state_nx = ST_EOC_WAIT;
            ST_EOC_WAIT: begin
                if (!eoc_seen_n)          state_nx = ST_RD_LOW;
                else if (wait_expired)    state_nx = ST_RESULT;
            end
            ST_RD_LOW:     if (rd_done)   state_nx = ST_RD_GAP;
            ST_RD_GAP:     if (gap_done)  state_nx = ST_RD_HIGH;
            ST_RD_HIGH:    if (rd_done)   state_nx = ST_RD_RELEASE;
            ST_RD_RELEASE: if (gap_done)  state_nx = ST_RESULT;
            ST_RESULT:     if (res_ready) state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // state register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state_nx != state) ? '0 : cnt + 1'b1;
        end
    end

    // captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                ctrl_q <= req_ctrl;
                lo_q   <= '0;
                hi_q   <= '0;
                err_q  <= 1'b0;
            end
            if (state == ST_EOC_WAIT && eoc_seen_n && wait_expired)
                err_q <= 1'b1;
            if (state == ST_RD_LOW && rd_done)
                lo_q <= adc_dq_i;
            if (state == ST_RD_HIGH && rd_done)
                hi_q <= adc_dq_i[3:0];
        end
    end

    adc_result_join #(.LO_W(8), .RAW_W(12), .OUT_W(16)) u_join (
        .lo_byte (lo_q),
        .hi_part (hi_q),
        .bipolar (ctrl_q[BIP_BIT]),
        .value   (res_data)
    );

    // outputs
    always_comb begin
        adc_cs_n  = 1'b1;
        adc_wr_n  = 1'b1;
        adc_rd_n  = 1'b1;
        adc_hben  = 1'b0;
        adc_dq_oe = 1'b0;
        req_ready = 1'b0;
        res_valid = 1'b0;
        unique case (state)
            ST_IDLE:       req_ready = 1'b1;
            ST_WR_STROBE: begin
                adc_cs_n  = 1'b0;
                adc_wr_n  = 1'b0;
                adc_dq_oe = 1'b1;
            end
            ST_WR_HOLD:    adc_dq_oe = 1'b1;
            ST_EOC_WAIT:   ;
            ST_RD_LOW: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
            end
            ST_RD_GAP:     adc_hben = 1'b1;
            ST_RD_HIGH: begin
                adc_cs_n = 1'b0;
                adc_rd_n = 1'b0;
                adc_hben = 1'b1;
            end
            ST_RD_RELEASE: ;
            ST_RESULT:     res_valid = 1'b1;
            default:       ;
        endcase
    end

    assign adc_dq_o = ctrl_q;
    assign res_err  = err_q;

endmodule

// File: rtl/adc_bus_master_chk.sv
module adc_bus_master_chk #(
    parameter int NW = 4,
    parameter int NA = 6,
    parameter int NR = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        wr_n,
    input logic        rd_n,
    input logic        dq_oe,
    input logic        req_ready,
    input logic        res_valid,
    input logic        res_ready,
    input logic [15:0] res_data,
    input logic        res_err
);
    int wr_run;
    int rd_run;
    int rd_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run  <= 0;
            rd_run  <= 0;
            rd_idle <= NR;
        end else begin
            wr_run  <= wr_n ? 0 : wr_run + 1;
            rd_run  <= rd_n ? 0 : rd_run + 1;
            rd_idle <= !rd_n ? 0 : ((rd_idle < NR + NA) ? rd_idle + 1 : rd_idle);
        end
    end

    p_wr_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n);

    p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n && !$past(wr_n)) |-> (wr_run >= NW));

    p_rd_in_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n);

    p_rd_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && !$past(rd_n)) |-> (rd_run >= NA));

    p_rd_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> (rd_idle >= NR));

    p_no_drive_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !dq_oe);

    p_release_before_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> (rd_idle >= NR));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_err)));

    p_single_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid || !cs_n || dq_oe) |-> !req_ready);

endmodule

bind adc_bus_master adc_bus_master_chk #(
    .NW (NW_CYC),
    .NA (NA_CYC),
    .NR (NR_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (adc_cs_n),
    .wr_n      (adc_wr_n),
    .rd_n      (adc_rd_n),
    .dq_oe     (adc_dq_oe),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_err   (res_err)
);

// File: tb/test_adc_bus_master.sv
module test_adc_bus_master;
    localparam int B_TO = 40;
    localparam int B_NW = ((80 + 19) / 20 > (60 + 19) / 20) ? (80 + 19) / 20 : (60 + 19) / 20;
    localparam int B_NA = (120 + 19) / 20;
    localparam int B_NR = (70 + 19) / 20;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [7:0] req_ctrl = 0;
    logic res_ready = 0;
    logic req_ready, res_valid, res_err;
    logic [15:0] res_data;
    logic adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_dq_oe;
    logic [7:0] adc_dq_o, adc_dq_i;
    logic dev_int_n = 1;
    logic [7:0] dev_lo = 0, dev_hi = 0;

    int total = 0, bad = 0;
    int cyc = 0;
    int fire_at = -1;

    always #10 clk = ~clk;

    adc_bus_master #(.EOC_TIMEOUT(B_TO)) i_adc_bus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_ctrl(req_ctrl),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_err(res_err),
        .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_hben(adc_hben),
        .adc_dq_o(adc_dq_o), .adc_dq_oe(adc_dq_oe), .adc_dq_i(adc_dq_i), .adc_eoc_n(dev_int_n)
    );

    // converter model
    assign adc_dq_i = adc_hben ? dev_hi : dev_lo;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!adc_cs_n && !adc_rd_n) dev_int_n = 1'b1;
        else if (cyc == fire_at)    dev_int_n = 1'b0;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference: phase number plus cycles left in it
    int m_ph, m_left;
    logic [7:0] m_ctrl;
    logic m_s1, m_s2;
    logic [15:0] exp_data;
    logic exp_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_left <= 0; m_ctrl <= 0; m_s1 <= 1; m_s2 <= 1;
        end else begin
            m_s1 <= dev_int_n;
            m_s2 <= m_s1;
            if (m_ph == 0) begin
                if (req_valid) begin m_ph <= 1; m_left <= B_NW; m_ctrl <= req_ctrl; end
            end else if (m_ph == 3) begin
                if (!m_s2)            begin m_ph <= 4; m_left <= B_NA; end
                else if (m_left == 1) begin m_ph <= 8; end
                else m_left <= m_left - 1;
            end else if (m_ph == 8) begin
                if (res_ready) m_ph <= 0;
            end else if (m_left > 1) begin
                m_left <= m_left - 1;
            end else begin
                case (m_ph)
                    1: begin m_ph <= 2; m_left <= 1;    end
                    2: begin m_ph <= 3; m_left <= B_TO; end
                    4: begin m_ph <= 5; m_left <= B_NR; end
                    5: begin m_ph <= 6; m_left <= B_NA; end
                    6: begin m_ph <= 7; m_left <= B_NR; end
                    default: begin m_ph <= 8; m_left <= 0; end
                endcase
            end
        end
    end

    // per-cycle comparison: {cs, wr, rd, hben, oe}
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] act, ex;
            string tag;
            act = {adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_dq_oe};
            case (m_ph)
                1: begin ex = 5'b00101; tag = "R2 R3 write strobe"; end
                2: begin ex = 5'b11101; tag = "R2 write hold";      end
                3: begin ex = 5'b11100; tag = "R4 flag wait";       end
                4: begin ex = 5'b01000; tag = "R5 low read";        end
                5: begin ex = 5'b11110; tag = "R6 read gap";        end
                6: begin ex = 5'b01010; tag = "R6 high read";       end
                7: begin ex = 5'b11100; tag = "R7 release";         end
                default: begin ex = 5'b11100; tag = "R1 R10 idle/result"; end
            endcase
            check(act == ex, tag, act, ex);
            check(req_ready == (m_ph == 0), "R10 req_ready", req_ready, m_ph == 0);
            check(res_valid == (m_ph == 8), "R9 res_valid", res_valid, m_ph == 8);
            if (m_ph == 1 || m_ph == 2)
                check(adc_dq_o == m_ctrl, "R2 write data", adc_dq_o, m_ctrl);
            if (m_ph == 8) begin
                check(res_data == exp_data, "R8 R11 result data", res_data, exp_data);
                check(res_err == exp_err, "R9 R11 result error", res_err, exp_err);
            end
        end
    end

    function automatic logic [15:0] widen(input logic [7:0] lo, input logic [7:0] hi, input bit bip);
        int v;
        v = hi[3:0] * 256 + lo;
        if (bip && v >= 2048) v = v - 4096;
        return 16'(v);
    endfunction

    task automatic run_txn(input logic [7:0] ctrl, input logic [7:0] lo, input logic [7:0] hi,
                           input int eoc_delay, input int hold_cycles, input bit hold_valid,
                           input bit timeout);
        int start;
        dev_lo = lo; dev_hi = hi;
        exp_err  = timeout;
        exp_data = timeout ? 16'h0 : widen(lo, hi, ctrl[3]);
        @(negedge clk);
        req_ctrl = ctrl; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (hold_valid) req_ctrl = 8'hFF;
        else req_valid = 0;
        while (m_ph != 3) @(negedge clk);
        start = cyc;
        if (!timeout) fire_at = cyc + eoc_delay;
        while (!res_valid) @(negedge clk);
        if (timeout)
            check(cyc - start >= B_TO, "R11 wait length", cyc - start, B_TO);
        req_valid = 0;
        repeat (hold_cycles) @(negedge clk);
        check(res_data == exp_data && res_valid, "R8 R9 held result", res_data, exp_data);
        res_ready = 1;
        @(negedge clk);
        res_ready = 0;
        check(!res_valid && req_ready, "R9 R10 result taken", res_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_dq_oe} == 5'b11100, "R1 bus at reset",
              {adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_dq_oe}, 5'b11100);
        check(req_ready && !res_valid, "R1 handshake at reset", {req_ready, res_valid}, 2'b10);
        rst_n = 1;
        @(negedge clk);
        run_txn(8'h01, 8'hA5, 8'hF7, 3, 0, 0, 0);   // unipolar, junk upper nibble: R8
        run_txn(8'h08, 8'h34, 8'hF9, 7, 3, 0, 0);   // bipolar negative
        run_txn(8'h18, 8'hFF, 8'hF5, 1, 1, 0, 0);   // bipolar positive, junk nibble
        run_txn(8'h02, 8'h00, 8'h0C, 12, 5, 0, 0);  // unipolar with bit 11 set
        run_txn(8'h08, 8'h00, 8'h08, 2, 2, 1, 0);   // R10 request held during transaction
        run_txn(8'h0B, 8'h11, 8'h0F, 0, 2, 0, 1);   // R11 timeout
        run_txn(8'h0B, 8'h00, 8'h08, 4, 0, 0, 0);   // recovery after timeout
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule